// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block takes one interrupt request at a time, each carrying an 8-bit vector and a tag for its origin: software interrupt instruction, overflow trap, external interrupt or exception. Alongside the request it takes the current mode bits: protection enable, virtual-8086, the two-bit I/O privilege level and long-mode-active. In the first cycle after acceptance it decides where the request goes. Requests raised with protection off take the real-mode path. A software interrupt issued in virtual-8086 mode with insufficient I/O privilege ends in a general-protection fault. Every other protected request is handed on, through a one-cycle dispatch strobe, to a protected-mode or long-mode gate unit outside this block.

On the real-mode path the block first checks that the vector's four-byte table entry lies inside the table limit. It then checks that the stack has room for a six-byte frame. If both checks pass, it pushes the low FLAGS word, CS and IP through a 16-bit write port. It clears the interrupt-enable, trap and alignment-check flags once FLAGS has been pushed. It then reads the handler's IP and CS from the vector table through a read port with one cycle of latency. The new FLAGS, CS, IP and SP appear on result outputs together with a one-cycle done pulse. The table base and limit sit in a register that the surrounding core loads. The base resets to 0 and the limit to 0x03FF.

Top module: `rm_int_entry`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` is ignored while busy: it causes no extra memory traffic and does not change the result of the request in progress.
- R2: With `mode_pe`=0 the request takes the real-mode path whatever `mode_v86`, `mode_iopl` and `mode_lma` are. No dispatch strobe is raised.
- R3: With `mode_pe`=1, `mode_v86`=1, `mode_iopl`<3 and `req_src`=0 (software interrupt), the block raises `fault_pulse` with `fault_code`=1 (general protection, error code zero) in the cycle after acceptance. It makes no memory access.
- R4: Any other request with `mode_pe`=1 raises `dispatch_pulse` in the cycle after acceptance, with `dispatch_long` equal to `mode_lma`. It raises no fault and makes no memory access.
- R5: On the real-mode path, if vector*4+3 is greater than the table limit, the block raises `fault_code`=1 and writes nothing. This check takes priority over the stack check.
- R6: On the real-mode path, if SP is below 6, the block raises `fault_code`=2 (stack) and writes nothing. SP equal to 6 is accepted.
- R7: A real-mode entry writes three words, each at physical address (SS*16 + SP') modulo 2^ADDR_W, where SP' is the stack pointer after a decrement of 2. The writes are FLAGS[15:0] at SP-2, then CS at SP-4, then IP at SP-6, in consecutive cycles 2, 3 and 4 after acceptance. The final SP is SP-6. No error code is pushed.
- R8: The committed FLAGS equal the input FLAGS with bit 9 (interrupt enable), bit 8 (trap) and bit 18 (alignment check) cleared. The pushed FLAGS word still carries the original bits.
- R9: After the pushes the block reads the word at base+vector*4 in cycle 5 and the word at base+vector*4+2 in cycle 6. The first word becomes the new IP and the second the new CS.
- R10: A successful real-mode entry raises `done_pulse` exactly 8 cycles after the acceptance edge. The block is ready again in that same cycle.
- R11: The result outputs `new_flags`, `new_cs`, `new_ip` and `new_sp` reset to 0. They change only together with `done_pulse`, and never on a faulted or dispatched request.
- R12: The table base resets to 0 and the limit to 0x03FF. `tbl_load` replaces both, and later vector fetches and limit checks use the new values.
- R13: Overflow traps (`req_src`=1), external interrupts (2) and exceptions (3) run the same real-mode sequence as software interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vector | input | 8 | Interrupt vector |
| req_src | input | 2 | Origin: 0 software, 1 overflow, 2 external, 3 exception |
| mode_pe | input | 1 | Protection enable |
| mode_v86 | input | 1 | Virtual-8086 mode |
| mode_iopl | input | 2 | I/O privilege level |
| mode_lma | input | 1 | Long mode active |
| cur_flags | input | 32 | Current FLAGS |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Current instruction pointer |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| tbl_load | input | 1 | Load table base and limit |
| tbl_base_in | input | ADDR_W | New table base |
| tbl_limit_in | input | 16 | New table limit |
| mem_we | output | 1 | Stack word write strobe |
| mem_waddr | output | ADDR_W | Write physical address |
| mem_wdata | output | 16 | Write data |
| mem_re | output | 1 | Table word read strobe |
| mem_raddr | output | ADDR_W | Read physical address |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_re` |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_code | output | 2 | 0 none, 1 general protection, 2 stack |
| dispatch_pulse | output | 1 | One-cycle hand-off to a protected gate unit |
| dispatch_long | output | 1 | Hand-off targets the long-mode path |
| done_pulse | output | 1 | Real-mode entry complete |
| new_flags | output | 32 | Committed FLAGS |
| new_cs | output | 16 | Committed CS |
| new_ip | output | 16 | Committed IP |
| new_sp | output | 16 | Committed SP |

## Verification
The assertions assume that the mode bits, vector and origin tag are meaningful in the acceptance cycle. They also assume that `mem_rdata` is driven by a memory that answers one cycle after each read strobe. The bench drives request fields only at falling edges and holds them through the accepting edge. It returns read data from a registered model of the vector table. The bench raises `req_valid` during a busy sequence only to probe that it is ignored, and it changes the table register only while the block is idle.

// File: rtl/rm_int_pkg.sv
// Shared types for the real-mode interrupt entry sequencer.
// Assumes: FLAGS is 32 bits wide, with the bit positions given below.
package rm_int_pkg;
    typedef enum logic [1:0] {SRC_SWINT = 2'd0, SRC_OVF = 2'd1, SRC_EXT = 2'd2, SRC_EXC = 2'd3} src_e;
    typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_GP = 2'd1, FLT_STK = 2'd2} flt_e;
    typedef enum logic [1:0] {RT_REAL, RT_PROT, RT_LONG, RT_GPF} route_e;
    typedef enum logic [2:0] {S_IDLE, S_CHECK, S_PUSH_F, S_PUSH_CS, S_PUSH_IP,
                              S_RD_IP, S_RD_CS, S_FIN} seq_e;
    localparam int FLAG_TF = 8;
    localparam int FLAG_IF = 9;
    localparam int FLAG_AC = 18;
endpackage

// File: rtl/rm_int_classify.sv
// Combinational request classifier. Picks the path for a latched request
// and the fault, if any, found by the mode, table-limit and stack checks.
// Assumes: its inputs are stable registers held from the acceptance cycle.
module rm_int_classify
    import rm_int_pkg::*;
#(
    parameter int FRAME_BYTES = 6
) (
    input  logic        pe,
    input  logic        v86,
    input  logic        lma,
    input  logic [1:0]  iopl,
    input  logic [1:0]  src,
    input  logic [7:0]  vec,
    input  logic [15:0] limit,
    input  logic [15:0] sp,
    output route_e      route,
    output flt_e        fcode
);
    localparam logic [15:0] MIN_SP = 16'(FRAME_BYTES);

    logic [15:0] entry_last;
    assign entry_last = {6'd0, vec, 2'b11};

    // Mode dispatch first, then the real-mode checks in priority order.
    always_comb begin
        route = RT_REAL;
        fcode = FLT_NONE;
        if (!pe) begin
            if (entry_last > limit)
                fcode = FLT_GP;
            else if (sp < MIN_SP)
                fcode = FLT_STK;
        end else if (v86 && (iopl != 2'd3) && (src == SRC_SWINT)) begin
            route = RT_GPF;
            fcode = FLT_GP;
        end else if (lma) begin
            route = RT_LONG;
        end else begin
            route = RT_PROT;
        end
    end
endmodule

// File: rtl/rm_int_seq.sv
// Entry sequencer. Runs check, three pushes, two table reads and a commit.
// Exposes the working SP and the read-word select so the top can form addresses.
// Assumes: read data arrives one cycle after the read strobe.
module rm_int_seq
    import rm_int_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  route_e      route,
    input  flt_e        fcode,
    input  logic [31:0] in_flags,
    input  logic [15:0] in_cs,
    input  logic [15:0] in_ip,
    input  logic [15:0] in_sp,
    input  logic [15:0] rdata,
    output logic        ready,
    output logic        we,
    output logic [15:0] wdata,
    output logic [15:0] wsp,
    output logic        re,
    output logic        rd_hi,
    output logic        fault,
    output logic [1:0]  fault_code,
    output logic        disp,
    output logic        disp_long,
    output logic        done,
    output logic [31:0] o_flags,
    output logic [15:0] o_cs,
    output logic [15:0] o_ip,
    output logic [15:0] o_sp
);
    localparam logic [31:0] CLR_MASK =
        ~((32'd1 << FLAG_IF) | (32'd1 << FLAG_TF) | (32'd1 << FLAG_AC));

    seq_e        state;
    logic [31:0] wflags;
    logic [15:0] nip;
    logic        pass;

    assign pass = (route == RT_REAL) && (fcode == FLT_NONE);

    // State advance, working registers and the commit of results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wsp     <= '0;
            wflags  <= '0;
            nip     <= '0;
            o_flags <= '0;
            o_cs    <= '0;
            o_ip    <= '0;
            o_sp    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE:    if (start) state <= S_CHECK;
                S_CHECK: begin
                    if (pass) begin
                        state  <= S_PUSH_F;
                        wsp    <= in_sp - 16'd2;
                        wflags <= in_flags;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_PUSH_F: begin
                    wflags <= wflags & CLR_MASK;
                    wsp    <= wsp - 16'd2;
                    state  <= S_PUSH_CS;
                end
                S_PUSH_CS: begin
                    wsp   <= wsp - 16'd2;
                    state <= S_PUSH_IP;
                end
                S_PUSH_IP: state <= S_RD_IP;
                S_RD_IP:   state <= S_RD_CS;
                S_RD_CS: begin
                    nip   <= rdata;
                    state <= S_FIN;
                end
                S_FIN: begin
                    o_ip    <= nip;
                    o_cs    <= rdata;
                    o_sp    <= wsp;
                    o_flags <= wflags;
                    done    <= 1'b1;
                    state   <= S_IDLE;
                end
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Per-state port strobes and push data selection.
    always_comb begin
        ready      = (state == S_IDLE);
        we         = (state == S_PUSH_F) || (state == S_PUSH_CS) || (state == S_PUSH_IP);
        re         = (state == S_RD_IP) || (state == S_RD_CS);
        rd_hi      = (state == S_RD_CS);
        fault      = (state == S_CHECK) && (fcode != FLT_NONE);
        fault_code = fault ? fcode : FLT_NONE;
        disp       = (state == S_CHECK) && ((route == RT_PROT) || (route == RT_LONG));
        disp_long  = disp && (route == RT_LONG);
        case (state)
            S_PUSH_F:  wdata = wflags[15:0];
            S_PUSH_CS: wdata = in_cs;
            S_PUSH_IP: wdata = in_ip;
            default:   wdata = '0;
        endcase
    end
endmodule

// File: rtl/rm_int_entry.sv
// Top of the real-mode interrupt entry sequencer. Latches the request on
// acceptance, holds the interrupt table register and forms the physical
// stack and table addresses. Assumes: a 16-bit segment is shifted left by
// 4 bits and sums wrap modulo 2^ADDR_W.
module rm_int_entry
    import rm_int_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter int          FRAME_BYTES = 6,
    parameter logic [15:0] LIMIT_RST   = 16'h03FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_vector,
    input  logic [1:0]        req_src,
    input  logic              mode_pe,
    input  logic              mode_v86,
    input  logic [1:0]        mode_iopl,
    input  logic              mode_lma,
    input  logic [31:0]       cur_flags,
    input  logic [15:0]       cur_cs,
    input  logic [15:0]       cur_ip,
    input  logic [15:0]       cur_ss,
    input  logic [15:0]       cur_sp,
    input  logic              tbl_load,
    input  logic [ADDR_W-1:0] tbl_base_in,
    input  logic [15:0]       tbl_limit_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [15:0]       mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [15:0]       mem_rdata,
    output logic              fault_pulse,
    output logic [1:0]        fault_code,
    output logic              dispatch_pulse,
    output logic              dispatch_long,
    output logic              done_pulse,
    output logic [31:0]       new_flags,
    output logic [15:0]       new_cs,
    output logic [15:0]       new_ip,
    output logic [15:0]       new_sp
);
    logic              accept;
    logic [7:0]        l_vec;
    logic [1:0]        l_src, l_iopl;
    logic              l_pe, l_v86, l_lma;
    logic [31:0]       l_flags;
    logic [15:0]       l_cs, l_ip, l_ss, l_sp;
    logic [ADDR_W-1:0] tbl_base;
    logic [15:0]       tbl_limit;
    route_e            route;
    flt_e              fcode;
    logic [15:0]       wsp;
    logic              rd_hi;

    assign accept = req_valid && req_ready;

    // Capture the request and the machine state on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_vec <= '0; l_src <= '0; l_iopl <= '0;
            l_pe <= 1'b0; l_v86 <= 1'b0; l_lma <= 1'b0;
            l_flags <= '0; l_cs <= '0; l_ip <= '0; l_ss <= '0; l_sp <= '0;
        end else if (accept) begin
            l_vec <= req_vector; l_src <= req_src; l_iopl <= mode_iopl;
            l_pe <= mode_pe; l_v86 <= mode_v86; l_lma <= mode_lma;
            l_flags <= cur_flags; l_cs <= cur_cs; l_ip <= cur_ip;
            l_ss <= cur_ss; l_sp <= cur_sp;
        end
    end

    // Interrupt table register: base resets to zero, limit to LIMIT_RST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base  <= '0;
            tbl_limit <= LIMIT_RST;
        end else if (tbl_load) begin
            tbl_base  <= tbl_base_in;
            tbl_limit <= tbl_limit_in;
        end
    end

    rm_int_classify #(.FRAME_BYTES(FRAME_BYTES)) u_cls (
        .pe(l_pe), .v86(l_v86), .lma(l_lma), .iopl(l_iopl), .src(l_src),
        .vec(l_vec), .limit(tbl_limit), .sp(l_sp), .route(route), .fcode(fcode)
    );

    rm_int_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .route(route), .fcode(fcode),
        .in_flags(l_flags), .in_cs(l_cs), .in_ip(l_ip), .in_sp(l_sp),
        .rdata(mem_rdata), .ready(req_ready), .we(mem_we), .wdata(mem_wdata),
        .wsp(wsp), .re(mem_re), .rd_hi(rd_hi), .fault(fault_pulse),
        .fault_code(fault_code), .disp(dispatch_pulse), .disp_long(dispatch_long),
        .done(done_pulse), .o_flags(new_flags), .o_cs(new_cs), .o_ip(new_ip),
        .o_sp(new_sp)
    );

    // Physical addresses: segment*16 plus offset, and base plus vector*4.
    assign mem_waddr = ADDR_W'({l_ss, 4'b0000}) + ADDR_W'(wsp);
    assign mem_raddr = tbl_base + ADDR_W'({l_vec, rd_hi, 1'b0});
endmodule

// File: rtl/rm_int_entry_chk.sv
// Assertion checker for rm_int_entry, attached through bind.
// Assumes: the request fields are valid in the acceptance cycle.
module rm_int_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_src,
    input logic        mode_pe,
    input logic        mode_v86,
    input logic [1:0]  mode_iopl,
    input logic        mode_lma,
    input logic        mem_we,
    input logic        mem_re,
    input logic        fault_pulse,
    input logic [1:0]  fault_code,
    input logic        dispatch_pulse,
    input logic        dispatch_long,
    input logic        done_pulse,
    input logic [31:0] new_flags,
    input logic [15:0] new_cs,
    input logic [15:0] new_ip,
    input logic [15:0] new_sp
);
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_real_no_dispatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !mode_pe) |=> !dispatch_pulse);

    assert_v86_swint_gp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && mode_pe && mode_v86 && (mode_iopl != 2'd3) && (req_src == 2'd0))
        |=> (fault_pulse && (fault_code == 2'd1) && !mem_we && !mem_re));

    assert_protected_dispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && mode_pe && !(mode_v86 && (mode_iopl != 2'd3) && (req_src == 2'd0)))
        |=> (dispatch_pulse && (dispatch_long == $past(mode_lma)) && !fault_pulse));

    assert_fault_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> (!fault_pulse && !mem_we && !mem_re));

    assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!new_flags[9] && !new_flags[8] && !new_flags[18]));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_results_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |-> ($stable(new_flags) && $stable(new_cs) && $stable(new_ip) && $stable(new_sp)));
endmodule

bind rm_int_entry rm_int_entry_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .mode_pe(mode_pe), .mode_v86(mode_v86), .mode_iopl(mode_iopl),
    .mode_lma(mode_lma), .mem_we(mem_we), .mem_re(mem_re), .fault_pulse(fault_pulse),
    .fault_code(fault_code), .dispatch_pulse(dispatch_pulse), .dispatch_long(dispatch_long),
    .done_pulse(done_pulse), .new_flags(new_flags), .new_cs(new_cs), .new_ip(new_ip),
    .new_sp(new_sp)
);

// File: tb/rm_int_entry_test.sv
// Bench for rm_int_entry: a behavioural model queues the expected port
// values for every cycle of each request; a comparator checks them at
// every falling edge.
module rm_int_entry_test;
    localparam int AW = 20;
    localparam int AMASK = (1 << AW) - 1;

    typedef struct {
        bit rdy; bit we; int waddr; int wdata; bit re; int raddr;
        bit flt; int fcode; bit disp; bit dlong; bit done; string tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_vector = '0;
    logic [1:0] req_src = '0, mode_iopl = '0;
    logic mode_pe = 1'b0, mode_v86 = 1'b0, mode_lma = 1'b0;
    logic [31:0] cur_flags = '0;
    logic [15:0] cur_cs = '0, cur_ip = '0, cur_ss = '0, cur_sp = '0;
    logic tbl_load = 1'b0;
    logic [AW-1:0] tbl_base_in = '0;
    logic [15:0] tbl_limit_in = '0;
    logic req_ready, mem_we, mem_re, fault_pulse, dispatch_pulse, dispatch_long, done_pulse;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic [1:0] fault_code;
    logic [31:0] new_flags;
    logic [15:0] new_cs, new_ip, new_sp;

    int vectors = 0, miscompares = 0;
    bit cmp_on = 0;
    exp_t q[$];
    logic [15:0] vmem [int];
    int m_base = 0, m_lim = 16'h03FF;
    int e_flags = 0, e_cs = 0, e_ip = 0, e_sp = 0;

    always #2 clk = ~clk;

    rm_int_entry uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_src(req_src), .mode_pe(mode_pe), .mode_v86(mode_v86),
        .mode_iopl(mode_iopl), .mode_lma(mode_lma), .cur_flags(cur_flags), .cur_cs(cur_cs),
        .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp), .tbl_load(tbl_load),
        .tbl_base_in(tbl_base_in), .tbl_limit_in(tbl_limit_in), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .fault_pulse(fault_pulse), .fault_code(fault_code),
        .dispatch_pulse(dispatch_pulse), .dispatch_long(dispatch_long), .done_pulse(done_pulse),
        .new_flags(new_flags), .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp)
    );

    // Vector table memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= vmem.exists(int'(mem_raddr)) ? vmem[int'(mem_raddr)] : 16'hDEAD;
    end

    function automatic exp_t rec(string tag);
        exp_t e;
        e.rdy = 0; e.we = 0; e.waddr = 0; e.wdata = 0; e.re = 0; e.raddr = 0;
        e.flt = 0; e.fcode = 0; e.disp = 0; e.dlong = 0; e.done = 0; e.tag = tag;
        return e;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the queued expectation (idle when empty).
    always @(negedge clk) begin
        exp_t e;
        if (cmp_on) begin
            if (q.size() > 0) e = q.pop_front();
            else begin e = rec("R1"); e.rdy = 1; end
            chk(e.tag, "ready", int'(req_ready), int'(e.rdy));
            chk(e.tag, "we", int'(mem_we), int'(e.we));
            if (e.we) begin
                chk(e.tag, "waddr", int'(mem_waddr), e.waddr);
                chk(e.tag, "wdata", int'(mem_wdata), e.wdata);
            end
            chk(e.tag, "re", int'(mem_re), int'(e.re));
            if (e.re) chk(e.tag, "raddr", int'(mem_raddr), e.raddr);
            chk(e.tag, "fault", int'(fault_pulse), int'(e.flt));
            chk(e.tag, "fcode", int'(fault_code), e.fcode);
            chk(e.tag, "disp", int'(dispatch_pulse), int'(e.disp));
            if (e.disp) chk(e.tag, "dlong", int'(dispatch_long), int'(e.dlong));
            chk(e.tag, "done", int'(done_pulse), int'(e.done));
        end
    end

    function automatic int phys(int seg, int off);
        return ((seg << 4) + (off & 16'hFFFF)) & AMASK;
    endfunction

    // Offer a request, wait for acceptance, and queue the expected cycles.
    task automatic start_req(int vec, int src, bit pe, bit v86, int iopl, bit lma,
                             int flags, int cs, int ip, int ss, int sp, string tag);
        exp_t e;
        @(negedge clk);
        req_vector = 8'(vec); req_src = 2'(src); mode_pe = pe; mode_v86 = v86;
        mode_iopl = 2'(iopl); mode_lma = lma; cur_flags = flags; cur_cs = 16'(cs);
        cur_ip = 16'(ip); cur_ss = 16'(ss); cur_sp = 16'(sp); req_valid = 1;
        @(posedge clk);
        #1 req_valid = 0;
        e = rec(tag);
        if (!pe) begin
            if (vec * 4 + 3 > m_lim) begin
                e.flt = 1; e.fcode = 1; e.tag = "R5"; q.push_back(e);
            end else if (sp < 6) begin
                e.flt = 1; e.fcode = 2; e.tag = "R6"; q.push_back(e);
            end else begin
                int ta;
                ta = (m_base + vec * 4) & AMASK;
                e.tag = "R1"; q.push_back(e);
                e = rec("R7"); e.we = 1; e.waddr = phys(ss, sp - 2); e.wdata = flags & 16'hFFFF; q.push_back(e);
                e = rec("R7"); e.we = 1; e.waddr = phys(ss, sp - 4); e.wdata = cs; q.push_back(e);
                e = rec("R7"); e.we = 1; e.waddr = phys(ss, sp - 6); e.wdata = ip; q.push_back(e);
                e = rec("R9"); e.re = 1; e.raddr = ta; q.push_back(e);
                e = rec("R9"); e.re = 1; e.raddr = (ta + 2) & AMASK; q.push_back(e);
                e = rec("R10"); q.push_back(e);
                e = rec("R10"); e.rdy = 1; e.done = 1; q.push_back(e);
                e_flags = flags & ~((1 << 9) | (1 << 8) | (1 << 18));
                e_ip = int'(vmem[ta]);
                e_cs = int'(vmem[(ta + 2) & AMASK]);
                e_sp = (sp - 6) & 16'hFFFF;
            end
        end else if (v86 && iopl < 3 && src == 0) begin
            e.flt = 1; e.fcode = 1; e.tag = "R3"; q.push_back(e);
        end else begin
            e.disp = 1; e.dlong = lma; e.tag = "R4"; q.push_back(e);
        end
    endtask

    // Wait out the queued cycles, then compare the committed results.
    task automatic finish_req(string tag);
        wait (q.size() == 0);
        @(negedge clk);
        #1;
        chk("R8", {tag, " flags"}, int'(new_flags), e_flags);
        chk("R9", {tag, " ip"}, int'(new_ip), e_ip);
        chk("R9", {tag, " cs"}, int'(new_cs), e_cs);
        chk("R7", {tag, " sp"}, int'(new_sp), e_sp);
    endtask

    task automatic run(int vec, int src, bit pe, bit v86, int iopl, bit lma,
                       int flags, int cs, int ip, int ss, int sp, string tag);
        start_req(vec, src, pe, v86, iopl, lma, flags, cs, ip, ss, sp, tag);
        finish_req(tag);
    endtask

    task automatic load_tbl(int base, int lim);
        @(negedge clk);
        tbl_load = 1; tbl_base_in = AW'(base); tbl_limit_in = 16'(lim);
        @(posedge clk);
        #1 tbl_load = 0;
        m_base = base; m_lim = lim;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            vmem[i * 4] = 16'(16'hA000 + i);
            vmem[i * 4 + 2] = 16'(16'hC000 + i);
            vmem[32'h10000 + i * 4] = 16'(16'hB000 + i);
            vmem[32'h10000 + i * 4 + 2] = 16'(16'hD000 + i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        #1;
        // R11: results reset to zero
        chk("R11", "reset flags", int'(new_flags), 0);
        chk("R11", "reset cs", int'(new_cs), 0);
        chk("R11", "reset ip", int'(new_ip), 0);
        chk("R11", "reset sp", int'(new_sp), 0);
        // R12: base 0 after reset is used by the first fetch
        run(8'h08, 0, 0, 0, 0, 0, 32'h0004_0BD5, 16'h1234, 16'h5678, 16'h2000, 16'h0100, "R12 base0");
        // R2: protection off ignores the other mode bits
        run(8'h21, 0, 0, 1, 0, 1, 32'h0000_FFFF, 16'h1111, 16'h2222, 16'h3000, 16'h0200, "R2");
        // R13: the other three origins
        run(8'h04, 1, 0, 0, 0, 0, 32'h0004_0300, 16'h0AAA, 16'h0BBB, 16'h4000, 16'h0050, "R13 ovf");
        run(8'h09, 2, 0, 0, 0, 0, 32'h0000_0202, 16'h0CCC, 16'h0DDD, 16'h4000, 16'h0060, "R13 ext");
        run(8'h0E, 3, 0, 0, 0, 0, 32'h0004_0100, 16'h0EEE, 16'h0FFF, 16'h4000, 16'h0070, "R13 exc");
        // R5: limit boundary, last entry fits with limit 0x3FF
        run(8'hFF, 0, 0, 0, 0, 0, 32'h0000_0200, 16'h0101, 16'h0202, 16'h5000, 16'h1000, "R5 fits");
        load_tbl(0, 16'h03FE);
        run(8'hFF, 0, 0, 0, 0, 0, 32'h0000_0200, 16'h0303, 16'h0404, 16'h5000, 16'h1000, "R5 over");
        run(8'hFE, 0, 0, 0, 0, 0, 32'h0000_0000, 16'h0505, 16'h0606, 16'h5000, 16'h1000, "R5 below");
        // R5 priority over the stack check
        run(8'hFF, 0, 0, 0, 0, 0, 32'h0000_0000, 16'h0707, 16'h0808, 16'h5000, 16'h0002, "R5 prio");
        // R6: stack boundary
        run(8'h10, 0, 0, 0, 0, 0, 32'h0004_0300, 16'h0909, 16'h0A0A, 16'h6000, 16'h0006, "R6 six");
        run(8'h10, 0, 0, 0, 0, 0, 32'h0000_0000, 16'h0B0B, 16'h0C0C, 16'h6000, 16'h0005, "R6 five");
        // R3 and R4: protected requests
        run(8'h30, 0, 1, 1, 2, 0, 32'h0, 16'h1, 16'h2, 16'h7000, 16'h0100, "R3 iopl2");
        run(8'h30, 0, 1, 1, 0, 1, 32'h0, 16'h1, 16'h2, 16'h7000, 16'h0100, "R3 iopl0");
        run(8'h31, 0, 1, 1, 3, 0, 32'h0, 16'h1, 16'h2, 16'h7000, 16'h0100, "R4 iopl3");
        run(8'h32, 2, 1, 1, 0, 0, 32'h0, 16'h1, 16'h2, 16'h7000, 16'h0100, "R4 ext v86");
        run(8'h33, 1, 1, 0, 0, 1, 32'h0, 16'h1, 16'h2, 16'h7000, 16'h0100, "R4 long");
        // R12: reloaded base is used
        load_tbl(32'h10000, 16'h03FF);
        run(8'h40, 3, 0, 0, 0, 0, 32'h0004_0200, 16'h1357, 16'h2468, 16'h0800, 16'h0400, "R12 base");
        // R7: physical address wraps
        run(8'h41, 2, 0, 0, 0, 0, 32'h0000_0100, 16'h9999, 16'h8888, 16'hFFFF, 16'h0040, "R7 wrap");
        // R1: requests offered while busy are ignored
        start_req(8'h42, 0, 0, 0, 0, 0, 32'h0004_0000, 16'h4242, 16'h2424, 16'h0900, 16'h0300, "R1 busy");
        repeat (2) @(negedge clk);
        req_vector = 8'h55; req_valid = 1;
        repeat (3) @(negedge clk);
        req_valid = 0;
        finish_req("R1 busy");
        repeat (3) @(negedge clk);
        cmp_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule